// File: doc/BRIEF.md
# Descriptor-Chain DMA Engine

This block runs a list of 64-bit descriptors held in system memory. Each descriptor moves one data region between memory and a word-wide block data port, jumps to another part of the list, or does nothing. Software writes the list, programs the address of its first entry, chooses the direction, and pulses `start` while `dma_en` is high. The engine then runs without further help until a descriptor carrying the end flag completes, or until a descriptor is malformed.

Each descriptor is two 32-bit words at consecutive addresses. The first is the control word:

- bit 0: valid
- bit 1: end
- bit 2: interrupt
- bits 5:4: action (0 no-op, 1 reserved, 2 transfer, 3 link)
- bits 31:16: byte length

The second word is the start address of the data region or, for a link, the address of the next descriptor. Memory is reached through a single request/acknowledge word port. When host-to-card is selected, the engine reads memory and offers the words on `out_*`. When card-to-host is selected, it takes words from `in_*` and writes them to memory.

The controller is one state machine with eleven states:

- `ST_IDLE` goes to `ST_FETCH_CTL` on a start with DMA enabled.
- `ST_FETCH_CTL` goes to `ST_FETCH_ADR` on acknowledge.
- `ST_FETCH_ADR` goes to `ST_DECODE` on acknowledge.
- `ST_DECODE` goes to one of four states:
  - `ST_FAIL` for a descriptor that is invalid, reserved or misaligned;
  - `ST_RD_MEM` for a host-to-card transfer;
  - `ST_PULL` for a card-to-host transfer;
  - `ST_STEP` for a no-op or a link.
- `ST_RD_MEM` goes to `ST_PUSH` on acknowledge.
- `ST_PUSH` goes on port ready to `ST_RD_MEM`, or to `ST_STEP` after the last word.
- `ST_PULL` goes to `ST_WR_MEM` on port valid.
- `ST_WR_MEM` goes on acknowledge to `ST_PULL`, or to `ST_STEP` after the last word.
- `ST_STEP` goes to `ST_DONE` if end is set, otherwise back to `ST_FETCH_CTL`.
- `ST_DONE` and `ST_FAIL` both return to `ST_IDLE`.

Top module: `adma_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `out_valid`, `in_ready`, `xfer_done`, `xfer_err` and `desc_irq` are all 0.
- R2: A `start` pulse while `dma_en` is 0 has no effect: no memory request is issued, `busy` stays 0 and no completion pulse occurs.
- R3: The first control word is read from `desc_base` and its address word from `desc_base`+4. `mem_addr` and `mem_we` hold steady while a request waits for `mem_ack`.
- R4: With `card_to_host`=0, a transfer descriptor reads length/4 words from consecutive word addresses starting at its address word. It presents them in order on `out_data`, each held until `out_ready`.
- R5: With `card_to_host`=1, a transfer descriptor accepts length/4 words from `in_data` and writes them in order to consecutive word addresses starting at its address word.
- R6: A length field of 0 (bits 31:16) means 65536 bytes, that is 16384 words.
- R7: After a transfer or no-op descriptor (action 2 or 0) without the end flag, the next descriptor is fetched 8 bytes further on. A no-op moves no data.
- R8: A link descriptor (action 3) moves no data and sets the next fetch address to its address word.
- R9: When a descriptor with the end flag (bit 1) completes, `xfer_done` pulses for exactly one cycle, nothing further is fetched and `busy` returns to 0.
- R10: `desc_irq` pulses once for each completed descriptor whose interrupt flag (bit 2) is set.
- R11: A descriptor with valid (bit 0) clear, or with the reserved action 1, stops the engine with a one-cycle `xfer_err` pulse and no `xfer_done`. Words moved by earlier descriptors stay moved.
- R12: A transfer descriptor whose length is not a multiple of 4 stops the engine with `xfer_err` before any of its data moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | Allows a start to take effect |
| card_to_host | input | 1 | Direction: 1 writes port data to memory, 0 reads memory to the port |
| desc_base | input | 32 | Byte address of the first descriptor |
| start | input | 1 | One-cycle start request |
| mem_req | output | 1 | Memory word request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| out_valid | output | 1 | Word offered to the block port |
| out_data | output | 32 | Word to the block port |
| out_ready | input | 1 | Block port takes the word |
| in_valid | input | 1 | Block port offers a word |
| in_data | input | 32 | Word from the block port |
| in_ready | output | 1 | Engine takes the offered word |
| busy | output | 1 | A descriptor list is being processed |
| xfer_done | output | 1 | One-cycle pulse: end descriptor completed |
| xfer_err | output | 1 | One-cycle pulse: malformed descriptor |
| desc_irq | output | 1 | One-cycle pulse: descriptor with interrupt flag completed |

## Verification
Single-descriptor lists are tried in both directions, at lengths of one word, a few words and 4096 bytes. They run with the port either always ready or stalling every other cycle, so that word order and hold-under-backpressure are told apart from plain counting. A mixed list of transfer, no-op and link shows that the next-descriptor address follows the action and that a no-op moves nothing. Malformed entries are placed both first and after a good descriptor, which separates an early stop from a late one. The zero-length case distinguishes the 65536-byte reading from an empty transfer.

// File: rtl/adma_pkg.sv
`timescale 1ns/1ps
package adma_pkg;

    localparam int CTL_VALID_BIT = 0;
    localparam int CTL_END_BIT   = 1;
    localparam int CTL_INT_BIT   = 2;
    localparam int CTL_ACT_LSB   = 4;
    localparam int CTL_LEN_LSB   = 16;
    localparam int WORD_BYTES    = 4;
    localparam int DESC_BYTES    = 8;

    typedef enum logic [1:0] {
        ACT_NOP  = 2'd0,
        ACT_RSVD = 2'd1,
        ACT_XFER = 2'd2,
        ACT_LINK = 2'd3
    } act_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_CTL,
        ST_FETCH_ADR,
        ST_DECODE,
        ST_RD_MEM,
        ST_PUSH,
        ST_PULL,
        ST_WR_MEM,
        ST_STEP,
        ST_DONE,
        ST_FAIL
    } state_e;

endpackage

// File: rtl/adma_desc_decode.sv
`timescale 1ns/1ps
module adma_desc_decode
    import adma_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = LEN_W - 1
) (
    input  logic [31:0]      ctl_word,
    output logic             f_valid,
    output logic             f_end,
    output logic             f_int,
    output act_e             f_act,
    output logic [CNT_W-1:0] f_words,
    output logic             f_misaligned
);

    localparam logic [CNT_W-1:0] MAX_WORDS = {{(CNT_W-1){1'b0}}, 1'b1} << (LEN_W - 2);

    logic [LEN_W-1:0] len_bytes;
    logic             unused_ctl_bits;

    assign len_bytes       = ctl_word[CTL_LEN_LSB +: LEN_W];
    assign unused_ctl_bits = ^{ctl_word[15:6], ctl_word[3]};

    always_comb begin
        f_valid      = ctl_word[CTL_VALID_BIT];
        f_end        = ctl_word[CTL_END_BIT];
        f_int        = ctl_word[CTL_INT_BIT];
        f_act        = act_e'(ctl_word[CTL_ACT_LSB +: 2]);
        f_misaligned = |len_bytes[1:0];
        if (len_bytes == '0) begin
            f_words = MAX_WORDS;
        end else begin
            f_words = CNT_W'(len_bytes >> 2);
        end
    end

endmodule

// File: rtl/adma_word_counter.sv
`timescale 1ns/1ps
module adma_word_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec) begin
            count <= count - CNT_W'(1);
        end
    end

    assign last = (count == CNT_W'(1));

    AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (count != '0)); // R4

    AST_CNT_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R6

endmodule

// File: rtl/adma_ptr_unit.sv
`timescale 1ns/1ps
module adma_ptr_unit
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              link_load,
    input  logic              desc_step,
    input  logic              data_load,
    input  logic              data_step,
    input  logic [ADDR_W-1:0] adr_val,
    output logic [ADDR_W-1:0] desc_ptr,
    output logic [ADDR_W-1:0] data_ptr
);

    localparam logic [ADDR_W-1:0] DESC_INC = ADDR_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] WORD_INC = ADDR_W'(WORD_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ptr <= '0;
        end else if (base_load) begin
            desc_ptr <= base_val;
        end else if (link_load) begin
            desc_ptr <= adr_val;
        end else if (desc_step) begin
            desc_ptr <= desc_ptr + DESC_INC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_ptr <= '0;
        end else if (data_load) begin
            data_ptr <= adr_val;
        end else if (data_step) begin
            data_ptr <= data_ptr + WORD_INC;
        end
    end

    AST_DESC_PTR_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({base_load, link_load, desc_step})); // R7

    AST_DATA_PTR_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_load && data_step)); // R4

endmodule

// File: rtl/adma_engine.sv
`timescale 1ns/1ps
module adma_engine
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    localparam int CNT_W = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              card_to_host,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [31:0]       out_data,
    input  logic              out_ready,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              xfer_done,
    output logic              xfer_err,
    output logic              desc_irq
);

    localparam logic [ADDR_W-1:0] ADR_WORD_OFS = ADDR_W'(WORD_BYTES);

    state_e state_q, state_d;

    logic [31:0]       ctl_q;
    logic [31:0]       adr_q;
    logic [31:0]       word_q;
    logic              dir_q;

    logic              f_valid, f_end, f_int, f_misaligned;
    act_e              f_act;
    logic [CNT_W-1:0]  f_words;
    logic [CNT_W-1:0]  cnt_value;
    logic              cnt_last;
    logic [ADDR_W-1:0] desc_ptr, data_ptr;

    logic cap_ctl, cap_adr, cap_rd, cap_in, go;
    logic ld_link, stp_desc, ld_xfer, stp_data;
    logic bad_desc;

    adma_desc_decode #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_decode (
        .ctl_word     (ctl_q),
        .f_valid      (f_valid),
        .f_end        (f_end),
        .f_int        (f_int),
        .f_act        (f_act),
        .f_words      (f_words),
        .f_misaligned (f_misaligned)
    );

    adma_word_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_xfer),
        .load_val (f_words),
        .dec      (stp_data),
        .count    (cnt_value),
        .last     (cnt_last)
    );

    adma_ptr_unit #(
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_load (go),
        .base_val  (desc_base),
        .link_load (ld_link),
        .desc_step (stp_desc),
        .data_load (ld_xfer),
        .data_step (stp_data),
        .adr_val   (adr_q[ADDR_W-1:0]),
        .desc_ptr  (desc_ptr),
        .data_ptr  (data_ptr)
    );

    // A descriptor is rejected when it is not valid, carries the reserved
    // action, or asks for a transfer of a length that is not whole words.
    assign bad_desc = !f_valid || (f_act == ACT_RSVD) ||
                      ((f_act == ACT_XFER) && f_misaligned);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start && dma_en) state_d = ST_FETCH_CTL;
            ST_FETCH_CTL: if (mem_ack) state_d = ST_FETCH_ADR;
            ST_FETCH_ADR: if (mem_ack) state_d = ST_DECODE;
            ST_DECODE: begin
                if (bad_desc) begin
                    state_d = ST_FAIL;
                end else if (f_act == ACT_XFER) begin
                    state_d = dir_q ? ST_PULL : ST_RD_MEM;
                end else begin
                    state_d = ST_STEP;
                end
            end
            ST_RD_MEM:    if (mem_ack) state_d = ST_PUSH;
            ST_PUSH:      if (out_ready) state_d = cnt_last ? ST_STEP : ST_RD_MEM;
            ST_PULL:      if (in_valid) state_d = ST_WR_MEM;
            ST_WR_MEM:    if (mem_ack) state_d = cnt_last ? ST_STEP : ST_PULL;
            ST_STEP:      state_d = f_end ? ST_DONE : ST_FETCH_CTL;
            ST_DONE:      state_d = ST_IDLE;
            ST_FAIL:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs and internal strobes
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        out_valid = 1'b0;
        out_data  = '0;
        in_ready  = 1'b0;
        busy      = 1'b1;
        xfer_done = 1'b0;
        xfer_err  = 1'b0;
        desc_irq  = 1'b0;
        cap_ctl   = 1'b0;
        cap_adr   = 1'b0;
        cap_rd    = 1'b0;
        cap_in    = 1'b0;
        go        = 1'b0;
        ld_link   = 1'b0;
        stp_desc  = 1'b0;
        ld_xfer   = 1'b0;
        stp_data  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                go   = start && dma_en;
            end
            ST_FETCH_CTL: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr;
                cap_ctl  = mem_ack;
            end
            ST_FETCH_ADR: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + ADR_WORD_OFS;
                cap_adr  = mem_ack;
            end
            ST_DECODE: begin
                ld_xfer = !bad_desc && (f_act == ACT_XFER);
            end
            ST_RD_MEM: begin
                mem_req  = 1'b1;
                mem_addr = data_ptr;
                cap_rd   = mem_ack;
            end
            ST_PUSH: begin
                out_valid = 1'b1;
                out_data  = word_q;
                stp_data  = out_ready;
            end
            ST_PULL: begin
                in_ready = 1'b1;
                cap_in   = in_valid;
            end
            ST_WR_MEM: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = data_ptr;
                mem_wdata = word_q;
                stp_data  = mem_ack;
            end
            ST_STEP: begin
                desc_irq = f_int;
                ld_link  = !f_end && (f_act == ACT_LINK);
                stp_desc = !f_end && (f_act != ACT_LINK);
            end
            ST_DONE: xfer_done = 1'b1;
            ST_FAIL: xfer_err  = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // Captured descriptor words, data word and direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            adr_q  <= '0;
            word_q <= '0;
            dir_q  <= 1'b0;
        end else begin
            if (go)      dir_q  <= card_to_host;
            if (cap_ctl) ctl_q  <= mem_rdata;
            if (cap_adr) adr_q  <= mem_rdata;
            if (cap_rd)  word_q <= mem_rdata;
            if (cap_in)  word_q <= in_data;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !out_valid && !in_ready)); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R4

    AST_WRITE_ONLY_C2H: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> dir_q); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (!xfer_done && !busy)); // R9

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && xfer_err)); // R11

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> (!xfer_err && !busy)); // R11

endmodule

// File: tb/adma_engine_bench.sv
`timescale 1ns/1ps
module adma_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_en = 1'b0;
    logic        card_to_host = 1'b0;
    logic [31:0] desc_base = '0;
    logic        start = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        out_valid, out_ready, in_valid, in_ready;
    logic [31:0] out_data, in_data;
    logic        busy, xfer_done, xfer_err, desc_irq;

    always #2.5 clk = ~clk;

    adma_engine u_adma_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .dma_en       (dma_en),
        .card_to_host (card_to_host),
        .desc_base    (desc_base),
        .start        (start),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_ready    (out_ready),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .busy         (busy),
        .xfer_done    (xfer_done),
        .xfer_err     (xfer_err),
        .desc_irq     (desc_irq)
    );

    // ---------------- memory and port models ----------------
    logic [31:0] dmem [0:255];
    logic        stall = 1'b0;
    logic        mon_clr = 1'b1;
    logic [31:0] mon_base = '0;
    int unsigned src_n;

    function automatic logic [31:0] pat_rd(input logic [31:0] a);
        return a ^ 32'hC3A5_0000;
    endfunction

    function automatic logic [31:0] pat_wr(input int unsigned n);
        return 32'h7E00_0000 + n;
    endfunction

    function automatic logic [31:0] mkctl(input logic v, input logic e, input logic i,
                                          input logic [1:0] act, input logic [15:0] len);
        return {len, 10'b0, act, 1'b0, i, e, v};
    endfunction

    assign mem_rdata = !mem_ack ? 32'h0 :
                       (mem_addr < 32'h400) ? dmem[mem_addr[9:2]] : pat_rd(mem_addr);
    assign in_data   = pat_wr(src_n);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack;
    end

    always @(posedge clk) begin
        out_ready <= stall ? ~out_ready : 1'b1;
        in_valid  <= stall ? ~in_valid  : 1'b1;
        if (mon_clr)                 src_n <= 0;
        else if (in_valid && in_ready) src_n <= src_n + 1;
    end

    // ---------------- monitors ----------------
    int unsigned n_done, n_err_p, n_irq, n_req, n_words, n_bad;
    logic [31:0] exp_addr;

    always @(negedge clk) begin
        if (mon_clr) begin
            n_done = 0; n_err_p = 0; n_irq = 0; n_req = 0;
            n_words = 0; n_bad = 0; exp_addr = mon_base;
        end else begin
            if (xfer_done) n_done++;
            if (xfer_err)  n_err_p++;
            if (desc_irq)  n_irq++;
            if (mem_req)   n_req++;
            if (out_valid && out_ready) begin
                if (out_data != pat_rd(exp_addr)) n_bad++;
                exp_addr += 4;
                n_words++;
            end
            if (mem_req && mem_we && mem_ack) begin
                if (mem_addr != exp_addr || mem_wdata != pat_wr(n_words)) n_bad++;
                exp_addr += 4;
                n_words++;
            end
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] d);
        dmem[a[9:2]]        = c;
        dmem[a[9:2] + 8'd1] = d;
    endtask

    task automatic run(input logic [31:0] base, input logic dir, input logic en,
                       input logic [31:0] dbase, input int max_cycles);
        mon_base     = dbase;
        mon_clr      = 1'b1;
        card_to_host = dir;
        dma_en       = en;
        desc_base    = base;
        tick();
        tick();
        mon_clr = 1'b0;
        start   = 1'b1;
        tick();
        start   = 1'b0;
        for (int i = 0; i < max_cycles; i++) begin
            if (n_done + n_err_p > 0) break;
            tick();
        end
        repeat (3) tick();
    endtask

    typedef struct packed {
        logic        dir;
        logic        irq;
        logic        stl;
        logic [15:0] len;
        logic [31:0] dbase;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{1'b0, 1'b1, 1'b0, 16'd16,   32'h0001_0000},
        '{1'b0, 1'b0, 1'b1, 16'd4,    32'h0002_0000},
        '{1'b1, 1'b1, 1'b0, 16'd12,   32'h0003_0000},
        '{1'b1, 1'b0, 1'b1, 16'd64,   32'h0004_0000},
        '{1'b0, 1'b1, 1'b1, 16'd4096, 32'h0005_0000}
    };

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R9: actual busy %0d expected run to end", busy);
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) dmem[k] = '0;
        out_ready = 1'b1;
        in_valid  = 1'b1;
        repeat (4) tick();
        // R1: outputs while held in reset
        check("R1 busy in reset", busy, 0);
        check("R1 mem_req in reset", mem_req, 0);
        rst_n = 1'b1;
        tick();
        check("R1 busy after reset", busy, 0);
        check("R1 out_valid/in_ready", {out_valid, in_ready}, 0);
        check("R1 pulses", {xfer_done, xfer_err, desc_irq}, 0);

        // R2: start without enable
        put_desc(32'h0, mkctl(1, 1, 1, 2'd2, 16'd16), 32'h0001_0000);
        run(32'h0, 1'b0, 1'b0, 32'h0001_0000, 30);
        check("R2 no memory request", n_req, 0);
        check("R2 busy", busy, 0);
        check("R2 no done", n_done, 0);

        // Table: single end descriptor, both directions, stall patterns
        for (int v = 0; v < 5; v++) begin
            put_desc(32'h0, mkctl(1, 1, VECS[v].irq, 2'd2, VECS[v].len), VECS[v].dbase);
            put_desc(32'h8, 32'h0, 32'h0);
            stall = VECS[v].stl;
            run(32'h0, VECS[v].dir, 1'b1, VECS[v].dbase, 20000);
            if (VECS[v].dir) begin
                check("R5 words written", n_words, VECS[v].len / 4);
                check("R5 address/data order", n_bad, 0);
            end else begin
                check("R4 words presented", n_words, VECS[v].len / 4);
                check("R4 address/data order", n_bad, 0);
            end
            check("R9 done pulse", n_done, 1);
            check("R9 no fetch past end", n_err_p, 0);
            check("R9 busy cleared", busy, 0);
            check("R10 irq count", n_irq, VECS[v].irq);
        end
        stall = 1'b0;

        // R3 R7 R8 R10: chain from non-zero base with no-op and link
        put_desc(32'h40, mkctl(1, 0, 1, 2'd2, 16'd16), 32'h0006_0000);
        put_desc(32'h48, mkctl(1, 0, 0, 2'd0, 16'd0), 32'hDEAD_0000);
        put_desc(32'h50, mkctl(1, 0, 0, 2'd3, 16'd0), 32'h0000_0100);
        put_desc(32'h100, mkctl(1, 1, 1, 2'd2, 16'd8), 32'h0006_0010);
        run(32'h40, 1'b0, 1'b1, 32'h0006_0000, 2000);
        check("R3 R7 R8 words over chain", n_words, 6);
        check("R8 data order across link", n_bad, 0);
        check("R10 irq per flagged descriptor", n_irq, 2);
        check("R7 chain done", n_done, 1);
        check("R7 chain no error", n_err_p, 0);

        // R11: invalid first descriptor
        put_desc(32'h0, mkctl(0, 1, 1, 2'd2, 16'd16), 32'h0007_0000);
        run(32'h0, 1'b0, 1'b1, 32'h0007_0000, 200);
        check("R11 invalid err", n_err_p, 1);
        check("R11 invalid no done", n_done, 0);
        check("R11 invalid no data", n_words, 0);
        check("R11 invalid no irq", n_irq, 0);

        // R11: reserved action
        put_desc(32'h0, mkctl(1, 1, 0, 2'd1, 16'd16), 32'h0007_0000);
        run(32'h0, 1'b1, 1'b1, 32'h0007_0000, 200);
        check("R11 reserved err", n_err_p, 1);
        check("R11 reserved no data", n_words, 0);

        // R12: misaligned length
        put_desc(32'h0, mkctl(1, 1, 0, 2'd2, 16'd6), 32'h0007_0000);
        run(32'h0, 1'b0, 1'b1, 32'h0007_0000, 200);
        check("R12 misaligned err", n_err_p, 1);
        check("R12 misaligned no data", n_words, 0);
        check("R12 misaligned no done", n_done, 0);

        // R11: good descriptor then invalid one
        put_desc(32'h0, mkctl(1, 0, 0, 2'd2, 16'd8), 32'h0007_0000);
        put_desc(32'h8, mkctl(0, 1, 0, 2'd2, 16'd8), 32'h0007_1000);
        run(32'h0, 1'b1, 1'b1, 32'h0007_0000, 400);
        check("R11 late err", n_err_p, 1);
        check("R11 earlier words kept", n_words, 2);
        check("R11 late no done", n_done, 0);
        check("R11 late busy cleared", busy, 0);

        // R6: zero length means 65536 bytes
        put_desc(32'h0, mkctl(1, 1, 0, 2'd2, 16'd0), 32'h0008_0000);
        put_desc(32'h8, 32'h0, 32'h0);
        run(32'h0, 1'b0, 1'b1, 32'h0008_0000, 80000);
        check("R6 zero length words", n_words, 16384);
        check("R6 zero length order", n_bad, 0);
        check("R6 zero length done", n_done, 1);

        summary();
        $finish;
    end

endmodule